// File: doc/BRIEF.md
# Tone-Gated Bit and Byte Encoder for Dish Control Signalling

This block serialises one byte into nine pulse-width-coded symbols on a single carrier-gate output. That output switches an external 22 kHz oscillator onto the dish feed cable. Symbol timing comes from a free-running timer's tick strobe of roughly 500 us, not from the local clock. Every symbol is three ticks long. The gate stays silent for the first tick. It then carries tone for one tick to mark a '1', or for two ticks to mark a '0', and it is always silent again by the end of the third tick.

A controller hands over one byte at a time through a valid/ready handshake. Each byte comes with a flag that marks it as the opening byte of a message. The block sends the eight data bits most significant first. It then sends a ninth symbol that makes the total count of ones odd, and pulses done once the last symbol ends. A tick that arrives while the block is idle is held as pending. An opening byte throws that pending tick away, so its first symbol starts on a fresh tick boundary. A following byte keeps the pending tick, so the next byte runs straight on without losing a tick.

Top module: `diseqc_byte_enc`

## Requirements
- R1: While reset is asserted and after reset is released, gate_o is low, done_o is low and in_ready_o is high.
- R2: The gate is low during the first tick of each symbol. It goes high in the clock cycle after the tick that ends that first tick.
- R3: For a '1' symbol, the gate falls in the clock cycle after the second tick, giving one tick of tone. For a '0' symbol, it stays high through the second tick and falls after the third, giving two ticks of tone.
- R4: The gate is low after the third tick of every symbol and whenever the block is idle.
- R5: A byte goes out as nine symbols. The eight data bits come first, bit 7 first and bit 0 last.
- R6: The ninth symbol is '1' when the data byte holds an even number of ones, so the nine symbols always hold an odd number of ones.
- R7: When in_first_i is 1 at acceptance, a pending tick is discarded, including a tick on the acceptance cycle itself. When in_first_i is 0, a pending tick is kept and ends the first tick of the new byte.
- R8: The gate changes only in the cycle after a tick is consumed. Each symbol consumes exactly three ticks, so one byte consumes 27.
- R9: in_ready_o is high only while the block is idle. A valid held while the block is busy is ignored and does not change the byte in flight.
- R10: done_o is a one-cycle pulse in the cycle after the parity symbol's third tick. in_ready_o goes high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe from the free-running timebase |
| in_valid_i | input | 1 | Byte offered |
| in_ready_o | output | 1 | Block idle, can take a byte |
| in_data_i | input | DATA_W | Byte to send |
| in_first_i | input | 1 | Byte opens a message; discard any pending tick |
| gate_o | output | 1 | Carrier enable for the external oscillator |
| done_o | output | 1 | One-cycle pulse when the byte is finished |

## Verification
A byte is accepted on the clock edge where valid and ready are both high, and in_ready_o drops in the following cycle. Every later change of gate_o appears one cycle after the cycle in which a tick was consumed. done_o and the return of in_ready_o appear one cycle after the parity symbol's third tick. The bench drives inputs on the falling edge, and its reference model advances on the rising edge using the same sampled inputs as the design. Every output is compared on the next falling edge, so each expectation is checked in exactly the cycle it is due. Tone lengths are measured on finished opening bytes to decode the bits and their parity. Ticks are placed on the acceptance cycle and just before it to exercise the discard and keep paths.

// File: rtl/diseqc_enc_pkg.sv
package diseqc_enc_pkg;
  typedef enum logic [1:0] {
    PH_GAP  = 2'd0,
    PH_MARK = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;
endpackage

// File: rtl/diseqc_tick_latch.sv
module diseqc_tick_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic consume_i,
  input  logic flush_i,
  output logic evt_o
);
  logic pend_q;

  assign evt_o = pend_q | tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (flush_i)   pend_q <= 1'b0;
    else if (consume_i) pend_q <= 1'b0;
    else                pend_q <= pend_q | tick_i;
  end

  AST_FLUSH_DROPS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !pend_q); // R7
endmodule

// File: rtl/diseqc_parity.sv
module diseqc_parity #(
  parameter int unsigned WIDTH = 8,
  parameter bit          ODD   = 1'b1
) (
  input  logic [WIDTH-1:0] data_i,
  output logic             par_o
);
  generate
    if (ODD) begin : g_odd
      assign par_o = ~(^data_i);
    end else begin : g_even
      assign par_o = ^data_i;
    end
  endgenerate
endmodule

// File: rtl/diseqc_sym_seq.sv
module diseqc_sym_seq
  import diseqc_enc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              evt_i,
  output logic              busy_o,
  output logic              gate_o,
  output logic              done_o
);
  localparam int unsigned NSYM  = DATA_W + 1;
  localparam int unsigned IDX_W = $clog2(NSYM);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NSYM - 1);

  logic [NSYM-1:0]  sh_q;
  logic [IDX_W-1:0] idx_q;
  phase_e           ph_q;
  logic             busy_q, gate_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      ph_q   <= PH_GAP;
      busy_q <= 1'b0;
      gate_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        sh_q   <= {data_i, par_i};
        idx_q  <= '0;
        ph_q   <= PH_GAP;
        busy_q <= 1'b1;
        gate_q <= 1'b0;
      end else if (busy_q && evt_i) begin
        unique case (ph_q)
          PH_GAP: begin
            gate_q <= 1'b1;
            ph_q   <= PH_MARK;
          end
          PH_MARK: begin
            if (sh_q[NSYM-1]) gate_q <= 1'b0;  // '1': short tone
            ph_q <= PH_TAIL;
          end
          default: begin
            gate_q <= 1'b0;
            ph_q   <= PH_GAP;
            if (idx_q == LAST) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
              sh_q  <= {sh_q[NSYM-2:0], 1'b0};
            end
          end
        endcase
      end
    end
  end

  assign busy_o = busy_q;
  assign gate_o = gate_q;
  assign done_o = done_q;

  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST); // R5
  AST_GATE_HOLDS_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !evt_i && !start_i) |=> $stable(gate_q)); // R8
  AST_GATE_LOW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !gate_q); // R4
  AST_GATE_LOW_IN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ph_q == PH_GAP) |-> !gate_q); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q); // R10
endmodule

// File: rtl/diseqc_byte_enc.sv
module diseqc_byte_enc #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_first_i,
  output logic              gate_o,
  output logic              done_o
);
  logic busy, evt, start, par;

  assign in_ready_o = !busy;
  assign start      = in_valid_i && !busy;

  diseqc_tick_latch u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .consume_i (busy && evt),
    .flush_i   (start && in_first_i),
    .evt_o     (evt)
  );

  diseqc_parity #(.WIDTH(DATA_W), .ODD(1'b1)) u_par (
    .data_i (in_data_i),
    .par_o  (par)
  );

  diseqc_sym_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .data_i  (in_data_i),
    .par_i   (par),
    .evt_i   (evt),
    .busy_o  (busy),
    .gate_o  (gate_o),
    .done_o  (done_o)
  );

  AST_READY_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> in_ready_o); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o); // R9
endmodule

// File: tb/tb_diseqc_byte_enc.sv
module tb_diseqc_byte_enc;
  localparam int TP = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] data = '0;
  logic       first = 1'b0;
  logic       ready, gate, done;
  logic       tick;
  int         tcnt = 0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  always @(posedge clk) tcnt <= (tcnt == TP - 1) ? 0 : tcnt + 1;
  assign tick = rst_n && (tcnt == TP - 1);

  diseqc_byte_enc dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .in_valid_i(valid), .in_ready_o(ready), .in_data_i(data),
    .in_first_i(first), .gate_o(gate), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit m_pend, m_busy, m_gate, m_done;
  int m_ph;
  bit m_q[$];
  bit [7:0] sent_q[$];
  bit       sent_first_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_busy = 0; m_gate = 0; m_done = 0; m_ph = 0;
      m_q.delete();
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_pend || tick) begin
          m_pend = 0;
          if (m_ph == 0) begin m_gate = 1; m_ph = 1; end
          else if (m_ph == 1) begin if (m_q[0]) m_gate = 0; m_ph = 2; end
          else begin
            m_gate = 0; m_ph = 0;
            void'(m_q.pop_front());
            if (m_q.size() == 0) begin m_busy = 0; m_done = 1; end
          end
        end
      end else begin
        if (valid) begin
          m_busy = 1; m_ph = 0; m_gate = 0;
          for (int i = 7; i >= 0; i--) m_q.push_back(data[i]);
          m_q.push_back(($countones(data) % 2) == 0);
          sent_q.push_back(data);
          sent_first_q.push_back(first);
          m_pend = first ? 1'b0 : (m_pend | tick);
        end else begin
          m_pend = m_pend | tick;
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (rst_n) begin
    chk("R2 R3 R4 R7 R8 gate", gate, m_gate);
    chk("R9 ready", ready, !m_busy);
    chk("R10 done", done, m_done);
  end

  // decode tone lengths of opening bytes
  bit g_prev = 0;
  int hlen = 0;
  bit dec_q[$];
  always @(negedge clk) if (rst_n) begin
    if (gate) hlen++;
    if (g_prev && !gate) begin
      dec_q.push_back(hlen < (3 * TP) / 2);
      hlen = 0;
    end
    g_prev = gate;
    if (done && sent_q.size() > 0) begin
      bit [7:0] b = sent_q.pop_front();
      bit f = sent_first_q.pop_front();
      if (f) begin
        int ones = 0;
        bit [7:0] got = '0;
        chk("R5 symbol count", dec_q.size(), 9);
        if (dec_q.size() == 9) begin
          for (int i = 0; i < 8; i++) got[7 - i] = dec_q[i];
          for (int i = 0; i < 9; i++) ones += dec_q[i];
          chk("R5 msb-first data", got, b);
          chk("R6 parity symbol", dec_q[8], ($countones(b) % 2) == 0);
          chk("R6 odd total", ones % 2, 1);
        end
      end
      dec_q.delete();
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  // mode 0: plain, 1: accept on a tick cycle, 2: accept just after an idle tick
  task automatic send(input bit [7:0] d, input bit f, input int mode);
    wait_idle();
    if (mode == 1) while (tcnt != TP - 1) @(negedge clk);
    if (mode == 2) begin
      while (tcnt != TP - 1) @(negedge clk);
      @(negedge clk);
    end
    valid = 1; data = d; first = f;
    @(negedge clk);
    valid = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset gate", gate, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset ready", ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle ready", ready, 1);

    send(8'hE0, 1, 0);
    send(8'h10, 0, 0);
    send(8'h38, 0, 0);
    send(8'h00, 1, 1);   // R7 tick on accept cycle discarded
    send(8'hFF, 1, 2);   // R7 pending idle tick discarded
    send(8'h01, 0, 2);   // R7 pending idle tick kept
    send(8'hA5, 0, 1);   // R7 tick on accept cycle kept
    send(8'h81, 1, 0);

    // R9: valid held while busy must not alter the byte in flight
    send(8'h5A, 1, 0);
    valid = 1; data = 8'h33; first = 1;
    repeat (20) @(negedge clk);
    chk("R9 ready low while busy", ready, 0);
    valid = 0;

    send(8'h7E, 1, 0);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R4 gate idle", gate, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule